// File: doc/BRIEF.md
# Host-Sequenced DES Round Datapath

This block is a DES datapath that a processor runs one round per command. The host loads a 64-bit key and a 64-bit block, each as two 32-bit words. It then issues sixteen round commands and reads the result back as two 32-bit words. No round counter or schedule sits inside the block. Every round command carries its own rotate amount (one or two positions) and its own direction (encrypt or decrypt). The host therefore owns the key schedule sequence and can stop, insert idle cycles or restart at any point.

The state is the two 28-bit key halves (C, D), the two 32-bit block halves (L, R) and two staging registers for the first word of each 64-bit load. A small command controller sequences the loads and has three states:
- `S_IDLE`: no load is pending.
- `S_KEY_HALF`: the high key word has been staged.
- `S_DATA_HALF`: the high data word has been staged.

The controller has these transitions:
- A key-high command goes to `S_KEY_HALF`.
- A data-high command goes to `S_DATA_HALF`.
- Any other valid command returns to `S_IDLE`.
- An idle cycle (`cmd_valid` low) holds the current state.

A low word is accepted only in the matching half state, so it commits only when it directly follows its high word.

Top module: `des_step_engine`

## Requirements
- R1: After reset the key halves, block halves and staging registers are zero, so `rd_data` reads 0 for both `rd_sel` values.
- R2: Op 1 (key high) stages `cmd_word` as key bits 63:32. Op 2 (key low), when it directly follows op 1, loads C/D with permuted choice 1 of {staged, `cmd_word`}. This reload resets C/D even in the middle of a round sequence.
- R3: Op 3 (data high) stages `cmd_word` as block bits 63:32. Op 4 (data low), when it directly follows op 3, loads L/R with the initial permutation of {staged, `cmd_word`}.
- R4: Op 2 or op 4 issued when it does not directly follow its own high-word command leaves all state unchanged.
- R5: Op 5 (round) with `cmd_decrypt`=0 rotates C and D left by 1 (`cmd_shift2`=0) or 2 (`cmd_shift2`=1). It then forms the subkey by permuted choice 2 of the rotated halves.
- R6: Op 5 with `cmd_decrypt`=1 forms the subkey from the current C/D. It then rotates C and D right by 1 or 2.
- R7: A round completes in one cycle: new L = old R, and new R = old L XOR P(S(subkey XOR E(old R))).
- R8: `rd_data` is combinational. It gives bits 63:32 (`rd_sel`=1) or bits 31:0 (`rd_sel`=0) of the final permutation of {R, L}.
- R9: After a key load, a data load and 16 encrypt rounds with shifts 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1, the readback is the DES ciphertext. Decrypt rounds with shifts 1,2,2,2,2,2,2,1,2,2,2,2,2,2,1,1 recover the plaintext. After either full sequence, C/D are back at their loaded value.
- R10: Cycles with `cmd_valid` low, and op codes 0, 6 and 7, change no key or block state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command code: 1 key high, 2 key low, 3 data high, 4 data low, 5 round |
| cmd_word | input | 32 | Key or data word for load commands |
| cmd_shift2 | input | 1 | Round rotate amount: 0 means one position, 1 means two |
| cmd_decrypt | input | 1 | Round direction: 1 selects decrypt ordering and right rotation |
| rd_sel | input | 1 | Readback word select: 1 high, 0 low |
| rd_data | output | 32 | Selected word of the final-permuted result |

## Verification
Known-answer vectors pin down the permutations, S-boxes and subkey ordering. These are an all-zero key and block, and a mixed-bit key and block. Random keys and blocks are run through an encryption, and then the ciphertext through a decryption with the same loaded key and random idle gaps between rounds. Recovering the plaintext separates correct rotation direction and subkey timing from errors that a single vector could mask. Directed cases cover the following:
- a stray low-word load;
- a key reload in the middle of a sequence;
- both readback halves after reset.

These tell apart a commit that ignores the controller state and a key schedule that fails to restart.

// File: rtl/des_step_pkg.sv
package des_step_pkg;

    localparam int HALF_W = 32;
    localparam int BLK_W  = 2 * HALF_W;
    localparam int KH_W   = 28;
    localparam int CD_W   = 2 * KH_W;
    localparam int SUB_W  = 48;
    localparam int NBOX   = 8;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_KEY_HI  = 3'd1,
        OP_KEY_LO  = 3'd2,
        OP_DATA_HI = 3'd3,
        OP_DATA_LO = 3'd4,
        OP_ROUND   = 3'd5
    } cmd_op_e;

    localparam int PC1_T [56] = '{
        57,49,41,33,25,17, 9, 1,58,50,42,34,26,18,
        10, 2,59,51,43,35,27,19,11, 3,60,52,44,36,
        63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
        14, 6,61,53,45,37,29,21,13, 5,28,20,12, 4};

    localparam int PC2_T [48] = '{
        14,17,11,24, 1, 5, 3,28,15, 6,21,10,
        23,19,12, 4,26, 8,16, 7,27,20,13, 2,
        41,52,31,37,47,55,30,40,51,45,33,48,
        44,49,39,56,34,53,46,42,50,36,29,32};

    localparam int P_T [32] = '{
        16, 7,20,21,29,12,28,17, 1,15,23,26, 5,18,31,10,
         2, 8,24,14,32,27, 3, 9,19,13,30, 6,22,11, 4,25};

    // one row of sixteen 4-bit outputs per entry, index = box*4 + row
    localparam logic [0:31][63:0] SBOX_ROWS = {
        64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538, 64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D,
        64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5, 64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9,
        64'hA09E63F51DC7B428, 64'hD709346A285ECBF1, 64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C,
        64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9, 64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E,
        64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986, 64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453,
        64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38, 64'h9EF528C3704A1DB6, 64'h432C95FABE17608D,
        64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86, 64'h14BDC37EAF680592, 64'h6BD814A7950FE23C,
        64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92, 64'h7B419CE206ADF358, 64'h21E74A8DFC90356B};

    // bits numbered 1..N from the MSB, as the standard tables do
    function automatic int ip_src(input int i);
        int r, c;
        r = i / 8;
        c = i % 8;
        return (r < 4) ? (58 + 2 * r - 8 * c) : (57 + 2 * (r - 4) - 8 * c);
    endfunction

    function automatic logic [BLK_W-1:0] init_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] o;
        for (int i = 0; i < BLK_W; i++) o[BLK_W-1-i] = x[BLK_W-ip_src(i)];
        return o;
    endfunction

    function automatic logic [BLK_W-1:0] final_perm(input logic [BLK_W-1:0] x);
        logic [BLK_W-1:0] o;
        for (int i = 0; i < BLK_W; i++) o[BLK_W-ip_src(i)] = x[BLK_W-1-i];
        return o;
    endfunction

    function automatic logic [CD_W-1:0] pc1(input logic [BLK_W-1:0] k);
        logic [CD_W-1:0] o;
        for (int i = 0; i < CD_W; i++) o[CD_W-1-i] = k[BLK_W-PC1_T[i]];
        return o;
    endfunction

    function automatic logic [SUB_W-1:0] pc2(input logic [CD_W-1:0] cd);
        logic [SUB_W-1:0] o;
        for (int i = 0; i < SUB_W; i++) o[SUB_W-1-i] = cd[CD_W-PC2_T[i]];
        return o;
    endfunction

    function automatic logic [KH_W-1:0] rot_left(input logic [KH_W-1:0] x, input logic two);
        return two ? {x[KH_W-3:0], x[KH_W-1:KH_W-2]} : {x[KH_W-2:0], x[KH_W-1]};
    endfunction

    function automatic logic [KH_W-1:0] rot_right(input logic [KH_W-1:0] x, input logic two);
        return two ? {x[1:0], x[KH_W-1:2]} : {x[0], x[KH_W-1:1]};
    endfunction

endpackage

// File: rtl/des_step_ctrl.sv
module des_step_ctrl
    import des_step_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output logic       key_stage,
    output logic       key_commit,
    output logic       data_stage,
    output logic       data_commit,
    output logic       round_fire
);

    typedef enum logic [1:0] {
        S_IDLE      = 2'd0,
        S_KEY_HALF  = 2'd1,
        S_DATA_HALF = 2'd2
    } ld_state_e;

    ld_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (cmd_valid) begin
            if (cmd_op == OP_KEY_HI)       state_d = S_KEY_HALF;
            else if (cmd_op == OP_DATA_HI) state_d = S_DATA_HALF;
            else                           state_d = S_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        key_stage   = cmd_valid && (cmd_op == OP_KEY_HI);
        data_stage  = cmd_valid && (cmd_op == OP_DATA_HI);
        round_fire  = cmd_valid && (cmd_op == OP_ROUND);
        key_commit  = 1'b0;
        data_commit = 1'b0;
        unique case (state_q)
            S_IDLE:      ;
            S_KEY_HALF:  key_commit  = cmd_valid && (cmd_op == OP_KEY_LO);
            S_DATA_HALF: data_commit = cmd_valid && (cmd_op == OP_DATA_LO);
            default:     ;
        endcase
    end

    // R2
    key_half_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_KEY_HI) |=> (state_q == S_KEY_HALF));

    // R4
    data_lone_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DATA_LO && $past(!(cmd_valid && cmd_op == OP_DATA_HI)))
        |-> !data_commit);

endmodule

// File: rtl/des_step_keysched.sv
module des_step_keysched
    import des_step_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stage_hi,
    input  logic              commit,
    input  logic              step,
    input  logic              shift2,
    input  logic              decrypt,
    input  logic [HALF_W-1:0] word,
    output logic [SUB_W-1:0]  subkey
);

    logic [HALF_W-1:0] hi_q;
    logic [KH_W-1:0]   c_q, d_q, c_rot, d_rot;

    always_comb begin
        if (decrypt) begin
            c_rot  = rot_right(c_q, shift2);
            d_rot  = rot_right(d_q, shift2);
            subkey = pc2({c_q, d_q});
        end else begin
            c_rot  = rot_left(c_q, shift2);
            d_rot  = rot_left(d_q, shift2);
            subkey = pc2({c_rot, d_rot});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            c_q  <= '0;
            d_q  <= '0;
        end else begin
            if (stage_hi) hi_q <= word;
            if (commit)    {c_q, d_q} <= pc1({hi_q, word});
            else if (step) {c_q, d_q} <= {c_rot, d_rot};
        end
    end

    // R5
    enc_rot_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !decrypt && shift2 && !commit) |=> (c_q == {$past(c_q[KH_W-3:0]), $past(c_q[KH_W-1:KH_W-2])}));

    // R6
    dec_rot_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && decrypt && !shift2 && !commit) |=> (d_q == {$past(d_q[0]), $past(d_q[KH_W-1:1])}));

    // R10
    cd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !commit) |=> ($stable(c_q) && $stable(d_q)));

endmodule

// File: rtl/des_step_ffunc.sv
module des_step_ffunc
    import des_step_pkg::*;
(
    input  logic [HALF_W-1:0] r_in,
    input  logic [SUB_W-1:0]  subkey,
    output logic [HALF_W-1:0] f_out
);

    logic [SUB_W-1:0]  mixed;
    logic [HALF_W-1:0] sub_out;

    always_comb begin
        for (int g = 0; g < NBOX; g++)
            for (int j = 0; j < 6; j++) begin
                int idx;
                idx = 4 * g + j;
                if (idx == 0)  idx = HALF_W;
                if (idx == 33) idx = 1;
                mixed[SUB_W-1-(6*g+j)] = r_in[HALF_W-idx];
            end
        mixed = mixed ^ subkey;
    end

    genvar b;
    generate
        for (b = 0; b < NBOX; b++) begin : g_box
            logic [5:0]  six;
            logic [1:0]  row;
            logic [63:0] line;
            assign six  = mixed[SUB_W-1-6*b -: 6];
            assign row  = {six[5], six[0]};
            assign line = SBOX_ROWS[b*4 + int'(row)];
            assign sub_out[HALF_W-1-4*b -: 4] = line[63 - 4*int'(six[4:1]) -: 4];
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < HALF_W; i++) f_out[HALF_W-1-i] = sub_out[HALF_W-P_T[i]];
    end

endmodule

// File: rtl/des_step_engine.sv
module des_step_engine
    import des_step_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  logic [31:0] cmd_word,
    input  logic        cmd_shift2,
    input  logic        cmd_decrypt,
    input  logic        rd_sel,
    output logic [31:0] rd_data
);

    logic key_stage, key_commit, data_stage, data_commit, round_fire;
    logic [SUB_W-1:0]  subkey;
    logic [HALF_W-1:0] l_q, r_q, dhi_q, f_val;
    logic [BLK_W-1:0]  out_blk;

    des_step_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .key_stage   (key_stage),
        .key_commit  (key_commit),
        .data_stage  (data_stage),
        .data_commit (data_commit),
        .round_fire  (round_fire)
    );

    des_step_keysched u_keys (
        .clk      (clk),
        .rst_n    (rst_n),
        .stage_hi (key_stage),
        .commit   (key_commit),
        .step     (round_fire),
        .shift2   (cmd_shift2),
        .decrypt  (cmd_decrypt),
        .word     (cmd_word),
        .subkey   (subkey)
    );

    des_step_ffunc u_f (
        .r_in   (r_q),
        .subkey (subkey),
        .f_out  (f_val)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dhi_q <= '0;
            l_q   <= '0;
            r_q   <= '0;
        end else begin
            if (data_stage) dhi_q <= cmd_word;
            if (data_commit) {l_q, r_q} <= init_perm({dhi_q, cmd_word});
            else if (round_fire) begin
                l_q <= r_q;
                r_q <= l_q ^ f_val;
            end
        end
    end

    assign out_blk = final_perm({r_q, l_q});
    assign rd_data = rd_sel ? out_blk[BLK_W-1:HALF_W] : out_blk[HALF_W-1:0];

    // R7
    l_takes_r_chk: assert property (@(posedge clk) disable iff (!rst_n)
        round_fire |=> (l_q == $past(r_q)));

    // R10
    lr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid || cmd_op == OP_NOP || cmd_op > OP_ROUND) |=> ($stable(l_q) && $stable(r_q)));

    // R4
    lr_lone_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_DATA_LO && $past(!(cmd_valid && cmd_op == OP_DATA_HI)))
        |=> ($stable(l_q) && $stable(r_q)));

endmodule

// File: tb/des_step_engine_tb.sv
`timescale 1ns/1ps
module des_step_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0;
    logic [31:0] cmd_word = '0;
    logic        cmd_shift2 = 1'b0;
    logic        cmd_decrypt = 1'b0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    des_step_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .cmd_shift2(cmd_shift2), .cmd_decrypt(cmd_decrypt),
        .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic bit enc_two(input int i);
        return !(i == 0 || i == 1 || i == 8 || i == 15);
    endfunction

    function automatic bit dec_two(input int i);
        return !(i == 0 || i == 7 || i == 14 || i == 15);
    endfunction

    task automatic check64(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [31:0] w, input bit s2, input bit dec);
        cmd_valid = 1'b1; cmd_op = op; cmd_word = w; cmd_shift2 = s2; cmd_decrypt = dec;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic load_key(input logic [63:0] k);
        issue(3'd1, k[63:32], 0, 0);
        issue(3'd2, k[31:0], 0, 0);
    endtask

    task automatic load_data(input logic [63:0] d);
        issue(3'd3, d[63:32], 0, 0);
        issue(3'd4, d[31:0], 0, 0);
    endtask

    task automatic run16(input bit dec, input bit gaps);
        for (int i = 0; i < 16; i++) begin
            issue(3'd5, $urandom, dec ? dec_two(i) : enc_two(i), dec);
            if (gaps && ($urandom_range(0, 3) == 0)) begin
                cmd_op = 3'($urandom_range(6, 7));
                @(negedge clk);
                @(negedge clk);
            end
        end
    endtask

    task automatic read64(output logic [63:0] v);
        cmd_valid = 1'b0;
        rd_sel = 1'b1; #1; v[63:32] = rd_data;
        rd_sel = 1'b0; #1; v[31:0]  = rd_data;
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] v, k, p, c;
        int seed;
        seed = $urandom(32'h5EED);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: zero state reads back as zero on both halves
        read64(v);
        check64("R1 reset readback", v, 64'h0);

        // R2 R3 R5 R7 R8 R9: known-answer encryption
        load_key(64'h133457799BBCDFF1);
        load_data(64'h0123456789ABCDEF);
        run16(0, 0);
        read64(v);
        check64("R9 encrypt vector A", v, 64'h85E813540F0AB405);

        // R6 R9: decrypt with same key, C/D back at loaded value
        load_data(64'h85E813540F0AB405);
        run16(1, 0);
        read64(v);
        check64("R6 decrypt vector A", v, 64'h0123456789ABCDEF);

        // R9: all-zero key and block
        load_key(64'h0);
        load_data(64'h0);
        run16(0, 1);
        read64(v);
        check64("R9 encrypt zero vector", v, 64'h8CA64DE9C1B123A7);
        load_data(64'h8CA64DE9C1B123A7);
        run16(1, 1);
        read64(v);
        check64("R6 decrypt zero vector", v, 64'h0);

        // R4: lone key-low word ignored
        load_key(64'h133457799BBCDFF1);
        issue(3'd2, 32'hDEADBEEF, 0, 0);
        load_data(64'h0123456789ABCDEF);
        issue(3'd4, 32'h0BADF00D, 0, 0);
        run16(0, 0);
        read64(v);
        check64("R4 lone low words ignored", v, 64'h85E813540F0AB405);

        // R4: high word then an interposed command voids the low word
        load_key(64'h133457799BBCDFF1);
        issue(3'd1, 32'hFFFFFFFF, 0, 0);
        issue(3'd0, 32'h0, 0, 0);
        issue(3'd2, 32'h12345678, 0, 0);
        load_data(64'h0123456789ABCDEF);
        run16(0, 0);
        read64(v);
        check64("R4 interrupted key load ignored", v, 64'h85E813540F0AB405);

        // R2: reload mid-sequence restarts the schedule
        load_key(64'h0);
        load_data(64'h0);
        for (int i = 0; i < 5; i++) issue(3'd5, 32'h0, enc_two(i), 0);
        load_key(64'h133457799BBCDFF1);
        load_data(64'h0123456789ABCDEF);
        run16(0, 0);
        read64(v);
        check64("R2 key reload mid-sequence", v, 64'h85E813540F0AB405);

        // R10: idle and undefined ops leave the result alone
        issue(3'd6, 32'hFFFFFFFF, 1, 1);
        issue(3'd7, 32'hFFFFFFFF, 1, 0);
        issue(3'd0, 32'hFFFFFFFF, 1, 0);
        repeat (3) @(negedge clk);
        read64(v);
        check64("R10 idle and unused ops", v, 64'h85E813540F0AB405);

        // R8: half selects map to the right words
        rd_sel = 1'b1; #1;
        check64("R8 high word", {32'h0, rd_data}, {32'h0, 32'h85E81354});
        rd_sel = 1'b0; #1;
        check64("R8 low word", {32'h0, rd_data}, {32'h0, 32'h0F0AB405});

        // R9: random round trips, key kept across encrypt and decrypt
        for (int t = 0; t < 24; t++) begin
            k = {$urandom, $urandom};
            p = {$urandom, $urandom};
            load_key(k);
            load_data(p);
            run16(0, 1);
            read64(c);
            load_data(c);
            run16(1, 1);
            read64(v);
            check64("R9 random round trip", v, p);
        end

        finish_run();
    end

endmodule